// File: doc/BRIEF.md
# Dependency Barrier Issue Controller

This block gates in-order issue for one warp scheduler using only the scheduling hints that the compiler packs into each instruction's 21-bit control word. It does not scoreboard registers. Each control word carries four things. A stall count fixes how long the next instruction of the same stream must wait. Optional write and read barrier numbers attach the instruction to one of six dependency counters. A wait mask names the counters that must be empty before the instruction may go. A yield bit, when clear, costs one extra cycle and raises a warp-switch hint.

The upstream fetch stage offers one instruction at a time with a valid/ready handshake, and issue happens on the clock edge where both are high. When a variable-latency instruction that holds a barrier issues, that barrier's counter goes up. The counter goes down when the execution side reports the matching register write completion or source-operand consumption. Instructions from warps that belong to a different scheduler (warp index modulo the scheduler count differs from this scheduler's index) are taken at once and have no effect.

Top module: `dbi_issue_ctl`

## Requirements
- R1: After reset all barrier counters are zero, `bar_busy` and `switch_hint` are 0, and the first own-warp instruction is accepted in the cycle it is offered.
- R2: Control word bits [3:0] hold the stall count S. After an own instruction with the yield bit (bit 4) set issues, the next own instruction is held for exactly S cycles. S=0 allows back-to-back issue.
- R3: When an own instruction issues with bit 4 clear, the hold is S+1 cycles and `switch_hint` is 1 in the cycle after issue. After any other issue it is 0.
- R4: Bits [7:5] name a write barrier. Issuing an own instruction adds one to that counter. A `wb_done_vld` pulse with `wb_done_id` subtracts one from it.
- R5: Bits [10:8] name a read barrier. It is counted up at issue in the same way and counted down by `rb_done_vld` with `rb_done_id`.
- R6: Bits [16:11] form the wait mask, where bit k stands for barrier k. An own instruction is held while any masked barrier has a nonzero count, and it issues once all of them are zero.
- R7: Barrier number 7 means none. Numbers 6 and 7 never change a counter, either as an issue binding or as a completion event.
- R8: Each counter saturates at 7 and does not go below 0. `bar_busy[k]` is 1 exactly when counter k is nonzero.
- R9: An increment and a decrement of the same barrier in the same cycle leave its count unchanged.
- R10: An instruction whose warp index modulo 4 differs from the scheduler index 0 is accepted at once. It does not change any counter, the stall timer or `switch_hint`.
- R11: The reuse bits [20:17] do not affect issue timing or barrier state.
- R12: While `in_valid` is high and `in_ready` is low, the offered warp and control word stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered |
| in_ready | output | 1 | The offered instruction issues at this edge |
| in_warp | input | WARP_W | Warp index of the offered instruction |
| in_ctrl | input | 21 | Control word of the offered instruction |
| wb_done_vld | input | 1 | A register write bound to a barrier has completed |
| wb_done_id | input | 3 | Barrier of the completed write |
| rb_done_vld | input | 1 | Source operands bound to a barrier have been consumed |
| rb_done_id | input | 3 | Barrier of the consumed operands |
| bar_busy | output | NUM_BAR | Per-barrier nonzero indicator |
| switch_hint | output | 1 | The previous issue asked to give up the warp |

## Verification
The properties assume that the fetch side keeps a refused instruction unchanged until it is taken. They also assume completion events come only for barriers that the execution side really owes, so no counter is driven past saturation by unmatched events. The stimulus holds warp and control word fixed from the moment it raises valid until the accepting edge. It sends each completion pulse only after the instruction that took the barrier has issued, with the exception of the deliberate same-cycle increment and decrement case, and the saturation run, which issues eight bindings against one counter on purpose. Events for barrier numbers 6 and 7 are injected to show that they are ignored.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
   localparam int BAR_ID_W = 3;
   localparam int WAIT_W   = 6;
   localparam int STALL_W  = 4;
   localparam int REUSE_W  = 4;

   localparam logic [BAR_ID_W-1:0] BAR_NONE = '1;

   // control word, most significant field first
   typedef struct packed {
      logic [REUSE_W-1:0]  reuse;
      logic [WAIT_W-1:0]   wait_m;
      logic [BAR_ID_W-1:0] rd_bar;
      logic [BAR_ID_W-1:0] wr_bar;
      logic                yld;
      logic [STALL_W-1:0]  stall;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/dbi_stall_timer.sv
module dbi_stall_timer #(
   parameter int LOAD_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LOAD_W-1:0] load_val,
   output logic              busy
);
   logic [LOAD_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n)
         remain <= '0;
      else if (load)
         remain <= load_val;
      else if (remain != '0)
         remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);
endmodule

// File: rtl/dbi_bar_ctr.sv
module dbi_bar_ctr #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [CNT_W-1:0] cnt,
   output logic             busy
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (inc && !dec) begin
         if (cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
      end
      else if (dec && !inc) begin
         if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
endmodule

// File: rtl/dbi_bar_dec.sv
module dbi_bar_dec #(
   parameter int NUM_BAR = 6,
   parameter int ID_W    = 3
) (
   input  logic               vld,
   input  logic [ID_W-1:0]    id,
   output logic [NUM_BAR-1:0] hit
);
   if (NUM_BAR >= (1 << ID_W)) begin : g_bad_range
      $error("dbi_bar_dec: NUM_BAR must leave room for the none code");
   end

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_hit
      assign hit[i] = vld && (id == ID_W'(i));
   end
endmodule

// File: rtl/dbi_issue_ctl.sv
module dbi_issue_ctl
   import dbi_pkg::*;
#(
   parameter int NUM_BAR       = 6,
   parameter int CNT_W         = 3,
   parameter int WARP_W        = 5,
   parameter int NUM_SCHED     = 4,
   parameter int SCHED_ID      = 0,
   parameter int YIELD_PENALTY = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WARP_W-1:0]   in_warp,
   input  logic [CTRL_W-1:0]   in_ctrl,
   input  logic                wb_done_vld,
   input  logic [BAR_ID_W-1:0] wb_done_id,
   input  logic                rb_done_vld,
   input  logic [BAR_ID_W-1:0] rb_done_id,
   output logic [NUM_BAR-1:0]  bar_busy,
   output logic                switch_hint
);
   localparam int LOAD_W = STALL_W + 1;

   if (NUM_BAR < 1 || NUM_BAR > WAIT_W) begin : g_bad_nbar
      $error("dbi_issue_ctl: NUM_BAR out of range of the wait mask");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("dbi_issue_ctl: CNT_W must be positive");
   end
   if (NUM_SCHED < 2 || SCHED_ID < 0 || SCHED_ID >= NUM_SCHED) begin : g_bad_sched
      $error("dbi_issue_ctl: scheduler index out of range");
   end
   if (YIELD_PENALTY < 0 || YIELD_PENALTY >= (1 << STALL_W)) begin : g_bad_pen
      $error("dbi_issue_ctl: YIELD_PENALTY does not fit the timer");
   end

   ctrl_t                  ctrl;
   logic                   own_warp;
   logic                   stall_busy;
   logic                   wait_hit;
   logic                   acc_own;
   logic [LOAD_W-1:0]      load_val;
   logic [NUM_BAR-1:0]     wr_hit, rd_hit, wb_hit, rb_hit;
   logic [NUM_BAR-1:0]     inc_vec, dec_vec;
   logic [NUM_BAR*CNT_W-1:0] cnt_flat;

   assign ctrl = ctrl_t'(in_ctrl);

   // warp to scheduler mapping
   if ((NUM_SCHED & (NUM_SCHED - 1)) == 0) begin : g_map_pow2
      localparam int SEL_W = $clog2(NUM_SCHED);
      assign own_warp = (in_warp[SEL_W-1:0] == SEL_W'(SCHED_ID));
   end
   else begin : g_map_mod
      assign own_warp = ((32'(in_warp) % NUM_SCHED) == SCHED_ID);
   end

   assign wait_hit = |(ctrl.wait_m[NUM_BAR-1:0] & bar_busy);
   assign in_ready = !own_warp || (!stall_busy && !wait_hit);
   assign acc_own  = in_valid && in_ready && own_warp;

   assign load_val = {1'b0, ctrl.stall}
                   + (ctrl.yld ? LOAD_W'(0) : LOAD_W'(YIELD_PENALTY));

   dbi_stall_timer #(.LOAD_W(LOAD_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (acc_own),
      .load_val (load_val),
      .busy     (stall_busy)
   );

   dbi_bar_dec #(.NUM_BAR(NUM_BAR), .ID_W(BAR_ID_W)) u_dec_wr (
      .vld (acc_own), .id (ctrl.wr_bar), .hit (wr_hit)
   );
   dbi_bar_dec #(.NUM_BAR(NUM_BAR), .ID_W(BAR_ID_W)) u_dec_rd (
      .vld (acc_own), .id (ctrl.rd_bar), .hit (rd_hit)
   );
   dbi_bar_dec #(.NUM_BAR(NUM_BAR), .ID_W(BAR_ID_W)) u_dec_wb (
      .vld (wb_done_vld), .id (wb_done_id), .hit (wb_hit)
   );
   dbi_bar_dec #(.NUM_BAR(NUM_BAR), .ID_W(BAR_ID_W)) u_dec_rb (
      .vld (rb_done_vld), .id (rb_done_id), .hit (rb_hit)
   );

   assign inc_vec = wr_hit | rd_hit;
   assign dec_vec = wb_hit | rb_hit;

   for (genvar k = 0; k < NUM_BAR; k++) begin : g_bar
      dbi_bar_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (inc_vec[k]),
         .dec   (dec_vec[k]),
         .cnt   (cnt_flat[k*CNT_W +: CNT_W]),
         .busy  (bar_busy[k])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         switch_hint <= 1'b0;
      else
         switch_hint <= acc_own && !ctrl.yld;
   end

   logic unused_ok;
   assign unused_ok = ^{ctrl.reuse, ctrl.wait_m};
endmodule

// File: rtl/dbi_issue_chk.sv
module dbi_issue_chk
   import dbi_pkg::*;
#(
   parameter int NUM_BAR = 6,
   parameter int CNT_W   = 3,
   parameter int WARP_W  = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     in_ready,
   input logic [WARP_W-1:0]        in_warp,
   input logic [CTRL_W-1:0]        in_ctrl,
   input logic [NUM_BAR-1:0]       bar_busy,
   input logic                     switch_hint,
   input logic                     own_warp,
   input logic                     acc_own,
   input logic                     stall_busy,
   input logic [NUM_BAR-1:0]       inc_vec,
   input logic [NUM_BAR-1:0]       dec_vec,
   input logic [NUM_BAR*CNT_W-1:0] cnt_flat
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   ctrl_t c;
   assign c = ctrl_t'(in_ctrl);

   // R6
   wait_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && own_warp) |-> ((c.wait_m[NUM_BAR-1:0] & bar_busy) == '0));

   // R2
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_own && c.stall != '0) |=> stall_busy);

   // R3
   hint_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_own && !c.yld) |=> switch_hint);

   // R10
   foreign_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !own_warp) |-> in_ready);

   // R12
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_ready) |=> (in_valid && $stable(in_ctrl) && $stable(in_warp)));

   for (genvar k = 0; k < NUM_BAR; k++) begin : g_bar_chk
      // R8
      no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_flat[k*CNT_W +: CNT_W] == CNT_MAX && inc_vec[k] && !dec_vec[k])
         |=> (cnt_flat[k*CNT_W +: CNT_W] == CNT_MAX));
      // R9
      same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (inc_vec[k] && dec_vec[k]) |=> $stable(cnt_flat[k*CNT_W +: CNT_W]));
      // R8
      busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bar_busy[k] == (cnt_flat[k*CNT_W +: CNT_W] != '0));
   end
endmodule

bind dbi_issue_ctl dbi_issue_chk #(
   .NUM_BAR (NUM_BAR),
   .CNT_W   (CNT_W),
   .WARP_W  (WARP_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .in_warp     (in_warp),
   .in_ctrl     (in_ctrl),
   .bar_busy    (bar_busy),
   .switch_hint (switch_hint),
   .own_warp    (own_warp),
   .acc_own     (acc_own),
   .stall_busy  (stall_busy),
   .inc_vec     (inc_vec),
   .dec_vec     (dec_vec),
   .cnt_flat    (cnt_flat)
);

// File: tb/sim_dbi_issue_ctl.sv
module sim_dbi_issue_ctl;
   import dbi_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int WARP_W     = 5;
   localparam int NUM_BAR    = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic                in_ready;
   logic [WARP_W-1:0]   in_warp = '0;
   logic [CTRL_W-1:0]   in_ctrl = '0;
   logic                wb_done_vld = 1'b0;
   logic [BAR_ID_W-1:0] wb_done_id = '0;
   logic                rb_done_vld = 1'b0;
   logic [BAR_ID_W-1:0] rb_done_id = '0;
   logic [NUM_BAR-1:0]  bar_busy;
   logic                switch_hint;

   int checks = 0;
   int errors = 0;

   typedef struct {
      int    dly;
      bit    hint;
      string req;
   } exp_t;
   exp_t q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dbi_issue_ctl #(.NUM_BAR(NUM_BAR), .WARP_W(WARP_W)) u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_warp     (in_warp),
      .in_ctrl     (in_ctrl),
      .wb_done_vld (wb_done_vld),
      .wb_done_id  (wb_done_id),
      .rb_done_vld (rb_done_vld),
      .rb_done_id  (rb_done_id),
      .bar_busy    (bar_busy),
      .switch_hint (switch_hint)
   );

   function automatic logic [CTRL_W-1:0] mk(input int stall, input bit yld,
                                            input int wr, input int rd,
                                            input int wmask, input int reuse);
      ctrl_t c;
      c.stall  = STALL_W'(stall);
      c.yld    = yld;
      c.wr_bar = BAR_ID_W'(wr);
      c.rd_bar = BAR_ID_W'(rd);
      c.wait_m = WAIT_W'(wmask);
      c.reuse  = REUSE_W'(reuse);
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: queues the expectation, then offers the instruction until taken
   task automatic send(input int w, input logic [CTRL_W-1:0] c, input int dly,
                       input bit h, input string req);
      exp_t e;
      bit rdy;
      e.dly = dly; e.hint = h; e.req = req;
      q.push_back(e);
      @(negedge clk);
      in_warp  = WARP_W'(w);
      in_ctrl  = c;
      in_valid = 1'b1;
      rdy = 1'b0;
      while (!rdy) begin
         #1;
         rdy = in_ready;
         if (!rdy) @(posedge clk);
      end
      @(posedge clk);
      in_valid <= 1'b0;
   endtask

   task automatic pulse(input bit rd, input int id, input int after);
      repeat (after) @(negedge clk);
      if (rd) begin rb_done_vld = 1'b1; rb_done_id = BAR_ID_W'(id); end
      else    begin wb_done_vld = 1'b1; wb_done_id = BAR_ID_W'(id); end
      @(negedge clk);
      if (rd) rb_done_vld = 1'b0;
      else    wb_done_vld = 1'b0;
   endtask

   task automatic burst(input bit rd, input int id, input int n);
      for (int i = 0; i < n; i++) pulse(rd, id, 1);
   endtask

   task automatic chk_busy(input int exp, input string req);
      #3;
      check(bar_busy == NUM_BAR'(exp), req, int'(bar_busy), exp);
   endtask

   // monitor: measures hold cycles of each offer and the hint that follows
   initial begin
      int  wait_cnt = 0;
      bit  hint_pend = 0;
      exp_t cur;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         #2;
         if (hint_pend) begin
            check(switch_hint == cur.hint, {cur.req, " hint"}, int'(switch_hint), int'(cur.hint));
            hint_pend = 0;
         end
         if (in_valid) begin
            if (in_ready) begin
               if (q.size() == 0) begin
                  check(1'b0, "issue without expectation", 1, 0);
               end
               else begin
                  cur = q.pop_front();
                  check(wait_cnt == cur.dly, {cur.req, " hold"}, wait_cnt, cur.dly);
                  hint_pend = 1;
               end
               wait_cnt = 0;
            end
            else begin
               wait_cnt++;
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #3;
      // R1 reset state
      check(bar_busy == '0, "R1 busy", int'(bar_busy), 0);
      check(switch_hint == 1'b0, "R1 hint", int'(switch_hint), 0);
      check(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);

      // R1 first issue, R2 stall countdown, R3 yield penalty and hint
      send(0, mk(3, 1, 7, 7, 0, 0), 0, 0, "R1 first");
      send(4, mk(0, 1, 7, 7, 0, 0), 3, 0, "R2 stall3");
      send(8, mk(0, 0, 7, 7, 0, 0), 0, 1, "R2 stall0");
      send(0, mk(5, 0, 7, 7, 0, 0), 1, 1, "R3 yield0");
      send(4, mk(0, 1, 7, 7, 0, 0), 6, 0, "R3 stall5 plus one");
      send(0, mk(0, 1, 7, 7, 0, 0), 0, 0, "R2 back to back");

      // R10 foreign warp passes through without effect
      send(0, mk(4, 1, 7, 7, 0, 0), 0, 0, "R10 own before");
      send(1, mk(9, 0, 1, 2, 6'h3f, 0), 0, 0, "R10 foreign");
      send(4, mk(0, 1, 7, 7, 0, 0), 3, 0, "R10 stall kept");
      @(negedge clk);
      chk_busy(0, "R10 no barrier");

      // R4 write barrier
      send(0, mk(0, 1, 2, 7, 0, 0), 0, 0, "R4 bind");
      @(negedge clk);
      chk_busy(6'b000100, "R4 busy");
      fork
         send(0, mk(0, 1, 7, 7, 6'b000100, 0), 3, 0, "R4 wait");
         pulse(0, 2, 3);
      join
      chk_busy(0, "R4 cleared");

      // R5 read barrier
      send(4, mk(0, 1, 7, 4, 0, 0), 0, 0, "R5 bind");
      @(negedge clk);
      chk_busy(6'b010000, "R5 busy");
      fork
         send(0, mk(0, 1, 7, 7, 6'b010000, 0), 2, 0, "R5 wait");
         pulse(1, 4, 2);
      join
      chk_busy(0, "R5 cleared");

      // R6 mask over two barriers
      send(0, mk(0, 1, 0, 7, 0, 0), 0, 0, "R6 bind0");
      send(0, mk(0, 1, 7, 1, 0, 0), 0, 0, "R6 bind1");
      fork
         send(4, mk(0, 1, 7, 7, 6'b000011, 0), 4, 0, "R6 wait both");
         pulse(0, 0, 2);
         pulse(1, 1, 4);
      join
      chk_busy(0, "R6 cleared");

      // R7 none and out-of-range numbers
      send(0, mk(0, 1, 7, 6, 0, 0), 0, 0, "R7 no bind");
      @(negedge clk);
      chk_busy(0, "R7 no bind busy");
      send(0, mk(0, 1, 5, 7, 0, 0), 0, 0, "R7 bind5");
      fork
         pulse(0, 7, 1);
         pulse(1, 6, 1);
      join
      chk_busy(6'b100000, "R7 events ignored");
      pulse(0, 5, 1);
      chk_busy(0, "R7 bind5 cleared");

      // R9 simultaneous increment and decrement
      send(0, mk(0, 1, 3, 7, 0, 0), 0, 0, "R9 bind");
      fork
         send(0, mk(0, 1, 3, 7, 0, 0), 0, 0, "R9 rebind");
         pulse(0, 3, 1);
      join
      chk_busy(6'b001000, "R9 count held");
      pulse(0, 3, 1);
      chk_busy(0, "R9 cleared");

      // R8 saturation, R11 reuse bits ignored
      for (int i = 0; i < 8; i++)
         send(4 * (i % 2), mk(0, 1, 0, 7, 0, 15), 0, 0, "R11 reuse set");
      burst(0, 0, 6);
      chk_busy(6'b000001, "R8 six drained");
      burst(0, 0, 1);
      chk_busy(0, "R8 saturated at 7");
      burst(0, 0, 1);
      chk_busy(0, "R8 floor");
      send(0, mk(0, 1, 0, 7, 0, 0), 0, 0, "R8 after floor");
      @(negedge clk);
      chk_busy(6'b000001, "R8 one pending");
      pulse(0, 0, 1);
      chk_busy(0, "R8 cleared");

      repeat (4) @(negedge clk);
      check(q.size() == 0, "all issues seen", q.size(), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule